// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block is the host-facing register window of a command mailbox. A host fills a byte-addressed payload area and a 64-bit command word, then sets a doorbell bit. The block takes over from there. It copies the payload into a private snapshot buffer and wipes the shared payload area. It then issues a one-cycle start pulse to an external command executor and waits for that executor's done pulse. On done, it writes the result back into the command and status words and drops the doorbell. The host polls the doorbell to learn that the command has finished.

Host accesses are 1, 2, 4 or 8 bytes wide and must be naturally aligned. The result of a read appears two cycles after the read strobe, with data right-justified in the low bytes. The status word carries a background-busy flag that is computed live from the background progress inputs. A separate read-only word presents those background inputs packed into fields.

Window layout, in byte offsets:

| Offset | Register |
|---|---|
| 0x00 | capability word, 32 bits |
| 0x04 | control word, 32 bits |
| 0x08 | command word |
| 0x10 | status word |
| 0x18 | background word |
| 0x20 and up | payload, 2^PAYLOAD_SHIFT bytes |

Top module: `mbx_doorbell_regs`

## Requirements
- R1: After reset, the control, command and status words read as zero. The capability word reads 0x1CB with the default parameters: bits [4:0] hold PAYLOAD_SHIFT (11), bit 6 holds 1, bits [10:7] hold MSG_NUM (3), and all other bits are 0.
- R2: Every access must be aligned to its own width. A size code of 0/1/2/3 selects 1/2/4/8 bytes. An 8-byte access at offset 0x00 is illegal. An illegal access writes nothing, and an illegal read returns 0.
- R3: Sub-word accesses are little-endian. A write of N bytes at offset A updates only bytes A to A+N-1 of its word. A read returns those bytes in the low bits with the upper bits set to zero.
- R4: Host writes to the capability word, the status word and the background word have no effect.
- R5: Bit 0 of the status word reads 0 when bg_pct equals 100 or bg_aborted is high. Otherwise it reads 1.
- R6: The background word reads as bg_opcode in bits [15:0], bg_pct in bits [22:16] and bg_rc in bits [47:32].
- R7: Legal accesses at or above 0x20 read and write the payload bytes at (offset − 0x20).
- R8: When the doorbell is accepted, the whole payload is first copied to the snapshot buffer, which the executor reads through exe_rd_addr/exe_rd_data, and then zeroed. Both steps finish before exe_start.
- R9: exe_start is a single-cycle pulse. It carries the command set (command bits [7:0]), the opcode (bits [15:8]) and the length (bits [36:16]) as they were when the doorbell was accepted.
- R10: On exe_done, the command word becomes {exe_out_len, opcode, command set} in the same field positions. The status word takes exe_rc in bits [47:32]. The doorbell (control bit 0) clears.
- R11: A length above 2^PAYLOAD_SHIFT produces no exe_start. In that case the block writes back ERR_RC (default 5), an output length of 0, and the original set and opcode, and clears the doorbell. A length equal to 2^PAYLOAD_SHIFT is accepted.
- R12: While a command is in progress, host writes to the control word, the command word and the payload are dropped.
- R13: Reads at offsets beyond the end of the payload return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | PAYLOAD_SHIFT+1 | Byte offset in the window |
| host_size | input | 2 | Access size code (1/2/4/8 bytes) |
| host_wdata | input | 64 | Write data, right-justified |
| host_rdata | output | 64 | Read data, right-justified |
| host_rvalid | output | 1 | Read data valid, two cycles after host_rd |
| bg_opcode | input | 16 | Background operation opcode |
| bg_pct | input | 7 | Background percent complete |
| bg_aborted | input | 1 | Background operation aborted |
| bg_rc | input | 16 | Background return code |
| exe_start | output | 1 | One-cycle command start |
| exe_set | output | 8 | Latched command set |
| exe_op | output | 8 | Latched opcode |
| exe_len | output | 21 | Latched input length |
| exe_done | input | 1 | Command finished |
| exe_rc | input | 16 | Return code, valid with exe_done |
| exe_out_len | input | 21 | Output length, valid with exe_done |
| exe_rd_addr | input | PAYLOAD_SHIFT-3 | Snapshot word address |
| exe_rd_data | output | 64 | Snapshot word, one cycle after address |
| exe_wr | input | 1 | Executor payload word write |
| exe_wr_addr | input | PAYLOAD_SHIFT-3 | Payload word address for executor write |
| exe_wr_data | input | 64 | Payload word data for executor write |

## Verification
The bench targets the following corner cases:

- **Alignment and sizes.** It issues misaligned and oversized accesses. It also issues an 8-byte write at offset 0 that would ring the doorbell if it were accepted, so a lax width check would start a spurious command.
- **Stale data.** It plants data in the payload before ringing the doorbell. It then checks that the executor sees that data through the snapshot while the shared payload reads back zero. A design that skipped or reordered the wipe would either leak stale bytes or hand the executor zeros.
- **Length limit.** It probes the length boundary on both sides, where an off-by-one would start or refuse the wrong command.
- **Writes while busy.** It writes the payload and command during execution, which a missing busy guard would let persist.
- **Live busy flag.** It drives the percent and abort inputs, which a latched flag would not follow.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int LEN_W = 21;
  localparam int RC_W  = 16;

  typedef enum logic [2:0] {
    RG_CAPCTL,
    RG_CMD,
    RG_STS,
    RG_BG,
    RG_PAY,
    RG_NONE
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_EXEC
  } mstate_e;
endpackage

// File: rtl/mbx_access_dec.sv
module mbx_access_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PW     = 256,
  localparam int WIW   = ADDR_W - 3,
  localparam int PIW   = $clog2(PW)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              ok,
  output region_e           region,
  output logic [7:0]        be,
  output logic [PIW-1:0]    pay_idx
);
  localparam logic [WIW-1:0] PAY_FIRST = WIW'(4);
  localparam logic [WIW-1:0] PAY_END   = WIW'(4 + PW);

  logic [WIW-1:0] widx;
  logic [2:0]     lane;
  logic           aligned;
  logic [7:0]     mask;
  logic [WIW-1:0] pay_off;

  assign widx    = addr[ADDR_W-1:3];
  assign lane    = addr[2:0];
  assign pay_off = widx - PAY_FIRST;
  assign pay_idx = pay_off[PIW-1:0];

  always_comb begin
    unique case (size)
      2'd0: begin aligned = 1'b1;              mask = 8'h01; end
      2'd1: begin aligned = (lane[0] == 1'b0);  mask = 8'h03; end
      2'd2: begin aligned = (lane[1:0] == 2'd0); mask = 8'h0F; end
      default: begin aligned = (lane == 3'd0);  mask = 8'hFF; end
    endcase
    be = mask << lane;
  end

  always_comb begin
    if (widx == WIW'(0))                           region = RG_CAPCTL;
    else if (widx == WIW'(1))                      region = RG_CMD;
    else if (widx == WIW'(2))                      region = RG_STS;
    else if (widx == WIW'(3))                      region = RG_BG;
    else if (widx >= PAY_FIRST && widx < PAY_END)  region = RG_PAY;
    else                                           region = RG_NONE;
  end

  assign ok = aligned && (region != RG_NONE) &&
              !((region == RG_CAPCTL) && (size == 2'd3));
endmodule

// File: rtl/mbx_bram.sv
module mbx_bram #(
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wbe,
  input  logic [63:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [63:0]   rdata
);
  logic [63:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 8; b++) begin
        if (wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int          PW     = 256,
  parameter logic [15:0] ERR_RC = 16'd5,
  localparam int PIW            = $clog2(PW),
  localparam int PBYTES         = PW * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             doorbell,
  input  logic [7:0]       cmd_set,
  input  logic [7:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             exe_done,
  input  logic [RC_W-1:0]  exe_rc,
  input  logic [LEN_W-1:0] exe_out_len,
  output logic             busy,
  output logic             exe_start,
  output logic [7:0]       exe_set,
  output logic [7:0]       exe_op,
  output logic [LEN_W-1:0] exe_len,
  output logic             sweep_rd,
  output logic [PIW-1:0]   sweep_raddr,
  output logic             sweep_we,
  output logic [PIW-1:0]   sweep_waddr,
  output logic             wb_fire,
  output logic [7:0]       wb_set,
  output logic [7:0]       wb_op,
  output logic [LEN_W-1:0] wb_len,
  output logic [RC_W-1:0]  wb_rc
);
  mstate_e        state;
  logic [PIW:0]   cnt;
  logic           pend_q;
  logic [PIW-1:0] pend_idx;
  logic           len_bad;
  logic           err_fire;

  assign len_bad     = cmd_len > LEN_W'(PBYTES);
  assign busy        = (state != ST_IDLE);
  assign sweep_rd    = (state == ST_SWEEP) && (cnt < (PIW+1)'(PW));
  assign sweep_raddr = cnt[PIW-1:0];
  assign sweep_we    = pend_q;
  assign sweep_waddr = pend_idx;
  assign err_fire    = (state == ST_IDLE) && doorbell && len_bad;
  assign wb_fire     = err_fire || ((state == ST_EXEC) && exe_done);

  always_comb begin
    if (err_fire) begin
      wb_set = cmd_set;
      wb_op  = cmd_op;
      wb_len = '0;
      wb_rc  = ERR_RC;
    end else begin
      wb_set = exe_set;
      wb_op  = exe_op;
      wb_len = exe_out_len;
      wb_rc  = exe_rc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pend_q    <= 1'b0;
      pend_idx  <= '0;
      exe_start <= 1'b0;
      exe_set   <= '0;
      exe_op    <= '0;
      exe_len   <= '0;
    end else begin
      exe_start <= 1'b0;
      pend_q    <= sweep_rd;
      pend_idx  <= cnt[PIW-1:0];
      unique case (state)
        ST_IDLE: begin
          if (doorbell && !len_bad) begin
            exe_set <= cmd_set;
            exe_op  <= cmd_op;
            exe_len <= cmd_len;
            cnt     <= '0;
            state   <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (sweep_rd) begin
            cnt <= cnt + 1'b1;
          end else begin
            exe_start <= 1'b1;
            state     <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (exe_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_doorbell_regs.sv
module mbx_doorbell_regs
  import mbx_pkg::*;
#(
  parameter int          PAYLOAD_SHIFT = 11,
  parameter int          MSG_NUM       = 3,
  parameter logic [15:0] ERR_RC        = 16'd5,
  localparam int ADDR_W                = PAYLOAD_SHIFT + 1,
  localparam int PW                    = 1 << (PAYLOAD_SHIFT - 3),
  localparam int PIW                   = PAYLOAD_SHIFT - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  output logic              host_rvalid,
  input  logic [15:0]       bg_opcode,
  input  logic [6:0]        bg_pct,
  input  logic              bg_aborted,
  input  logic [15:0]       bg_rc,
  output logic              exe_start,
  output logic [7:0]        exe_set,
  output logic [7:0]        exe_op,
  output logic [LEN_W-1:0]  exe_len,
  input  logic              exe_done,
  input  logic [RC_W-1:0]   exe_rc,
  input  logic [LEN_W-1:0]  exe_out_len,
  input  logic [PIW-1:0]    exe_rd_addr,
  output logic [63:0]       exe_rd_data,
  input  logic              exe_wr,
  input  logic [PIW-1:0]    exe_wr_addr,
  input  logic [63:0]       exe_wr_data
);
  localparam logic [31:0] CAP_WORD = 32'(PAYLOAD_SHIFT) | (32'd1 << 6) |
                                     (32'(MSG_NUM) << 7);

  // decode
  logic           acc_ok;
  region_e        acc_region;
  logic [7:0]     acc_be;
  logic [PIW-1:0] acc_pidx;
  logic [63:0]    wl;

  mbx_access_dec #(.ADDR_W(ADDR_W), .PW(PW)) u_dec (
    .addr(host_addr), .size(host_size), .ok(acc_ok),
    .region(acc_region), .be(acc_be), .pay_idx(acc_pidx)
  );

  assign wl = host_wdata << {host_addr[2:0], 3'b000};

  // sequencer
  logic             busy, sweep_rd, sweep_we, wb_fire;
  logic [PIW-1:0]   sweep_raddr, sweep_waddr;
  logic [7:0]       wb_set, wb_op;
  logic [LEN_W-1:0] wb_len;
  logic [RC_W-1:0]  wb_rc;
  logic [31:0]      ctrl_q;
  logic [63:0]      cmd_q;
  logic [RC_W-1:0]  rc_q;

  mbx_seq #(.PW(PW), .ERR_RC(ERR_RC)) u_seq (
    .clk(clk), .rst(rst), .doorbell(ctrl_q[0]),
    .cmd_set(cmd_q[7:0]), .cmd_op(cmd_q[15:8]), .cmd_len(cmd_q[36:16]),
    .exe_done(exe_done), .exe_rc(exe_rc), .exe_out_len(exe_out_len),
    .busy(busy), .exe_start(exe_start), .exe_set(exe_set), .exe_op(exe_op),
    .exe_len(exe_len), .sweep_rd(sweep_rd), .sweep_raddr(sweep_raddr),
    .sweep_we(sweep_we), .sweep_waddr(sweep_waddr), .wb_fire(wb_fire),
    .wb_set(wb_set), .wb_op(wb_op), .wb_len(wb_len), .wb_rc(wb_rc)
  );

  // register file
  logic reg_wr;
  assign reg_wr = host_wr && acc_ok && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmd_q  <= '0;
      rc_q   <= '0;
    end else if (wb_fire) begin
      cmd_q     <= {27'd0, wb_len, wb_op, wb_set};
      rc_q      <= wb_rc;
      ctrl_q[0] <= 1'b0;
    end else if (reg_wr) begin
      if (acc_region == RG_CAPCTL) begin
        for (int b = 0; b < 4; b++) begin
          if (acc_be[b+4]) ctrl_q[b*8 +: 8] <= wl[(b+4)*8 +: 8];
        end
      end
      if (acc_region == RG_CMD) begin
        for (int b = 0; b < 8; b++) begin
          if (acc_be[b]) cmd_q[b*8 +: 8] <= wl[b*8 +: 8];
        end
      end
    end
  end

  // payload and snapshot storage
  logic           pay_we;
  logic [PIW-1:0] pay_waddr, pay_raddr;
  logic [7:0]     pay_be;
  logic [63:0]    pay_wdata, pay_rdata;

  always_comb begin
    pay_we    = 1'b0;
    pay_waddr = acc_pidx;
    pay_be    = acc_be;
    pay_wdata = wl;
    if (sweep_we) begin
      pay_we    = 1'b1;
      pay_waddr = sweep_waddr;
      pay_be    = 8'hFF;
      pay_wdata = '0;
    end else if (busy && exe_wr) begin
      pay_we    = 1'b1;
      pay_waddr = exe_wr_addr;
      pay_be    = 8'hFF;
      pay_wdata = exe_wr_data;
    end else if (reg_wr && acc_region == RG_PAY) begin
      pay_we    = 1'b1;
    end
  end

  assign pay_raddr = sweep_rd ? sweep_raddr : acc_pidx;

  mbx_bram #(.WORDS(PW)) u_pay (
    .clk(clk), .we(pay_we), .waddr(pay_waddr), .wbe(pay_be),
    .wdata(pay_wdata), .raddr(pay_raddr), .rdata(pay_rdata)
  );

  mbx_bram #(.WORDS(PW)) u_snap (
    .clk(clk), .we(sweep_we), .waddr(sweep_waddr), .wbe(8'hFF),
    .wdata(pay_rdata), .raddr(exe_rd_addr), .rdata(exe_rd_data)
  );

  // read path: stage 1 captures, stage 2 registers the result
  logic        live_busy;
  logic [63:0] reg_word;
  logic        r1_valid, r1_ok, r1_pay, r1_pay_ok;
  logic [2:0]  r1_lane;
  logic [1:0]  r1_size;
  logic [63:0] r1_word;
  logic [63:0] r1_src;

  assign live_busy = !((bg_pct == 7'd100) || bg_aborted);

  always_comb begin
    unique case (acc_region)
      RG_CAPCTL: reg_word = {ctrl_q, CAP_WORD};
      RG_CMD:    reg_word = cmd_q;
      RG_STS:    reg_word = {16'd0, rc_q, 31'd0, live_busy};
      RG_BG:     reg_word = {16'd0, bg_rc, 9'd0, bg_pct, bg_opcode};
      default:   reg_word = '0;
    endcase
  end

  function automatic logic [63:0] pick(input logic [63:0] w,
                                       input logic [2:0] lane,
                                       input logic [1:0] sz);
    logic [63:0] s;
    s = w >> {lane, 3'b000};
    unique case (sz)
      2'd0:    pick = {56'd0, s[7:0]};
      2'd1:    pick = {48'd0, s[15:0]};
      2'd2:    pick = {32'd0, s[31:0]};
      default: pick = s;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_valid    <= 1'b0;
      r1_ok       <= 1'b0;
      r1_pay      <= 1'b0;
      r1_pay_ok   <= 1'b0;
      r1_lane     <= '0;
      r1_size     <= '0;
      r1_word     <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      r1_valid    <= host_rd;
      r1_ok       <= acc_ok;
      r1_pay      <= (acc_region == RG_PAY);
      r1_pay_ok   <= !busy;
      r1_lane     <= host_addr[2:0];
      r1_size     <= host_size;
      r1_word     <= reg_word;
      host_rvalid <= r1_valid;
      host_rdata  <= r1_ok ? pick(r1_src, r1_lane, r1_size) : 64'd0;
    end
  end

  assign r1_src = r1_pay ? (r1_pay_ok ? pay_rdata : 64'd0) : r1_word;
endmodule

// File: rtl/mbx_doorbell_regs_chk.sv
module mbx_doorbell_regs_chk
  import mbx_pkg::*;
#(
  parameter int PBYTES = 2048
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             acc_ok,
  input region_e          acc_region,
  input logic             busy,
  input logic             wb_fire,
  input logic [31:0]      ctrl_q,
  input logic [63:0]      cmd_q,
  input logic [15:0]      rc_q,
  input logic             exe_start,
  input logic [LEN_W-1:0] exe_len,
  input logic             exe_done
);
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    exe_start |=> !exe_start);

  // R11
  start_len_chk: assert property (@(posedge clk) disable iff (rst)
    exe_start |-> (exe_len <= LEN_W'(PBYTES)));

  // R10
  done_clears_bell_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && exe_done) |=> !ctrl_q[0]);

  // R2
  bad_access_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !acc_ok && !wb_fire) |=> ($stable(cmd_q) && $stable(ctrl_q)));

  // R4
  sts_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && acc_region == RG_STS && !wb_fire) |=> $stable(rc_q));

  // R12
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !exe_done) |=> $stable(cmd_q));
endmodule

bind mbx_doorbell_regs mbx_doorbell_regs_chk #(.PBYTES(PW * 8)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .acc_ok(acc_ok),
  .acc_region(acc_region), .busy(busy), .wb_fire(wb_fire),
  .ctrl_q(ctrl_q), .cmd_q(cmd_q), .rc_q(rc_q), .exe_start(exe_start),
  .exe_len(exe_len), .exe_done(exe_done)
);

// File: tb/mbx_doorbell_regs_bench.sv
`timescale 1ns/1ps
module mbx_doorbell_regs_bench;
  localparam int AW  = 12;
  localparam int PIW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid;
  logic [15:0] bg_opcode = '0;
  logic [6:0]  bg_pct = 7'd100;
  logic        bg_aborted = 1'b0;
  logic [15:0] bg_rc = '0;
  logic        exe_start;
  logic [7:0]  exe_set, exe_op;
  logic [20:0] exe_len;
  logic        exe_done = 1'b0;
  logic [15:0] exe_rc = '0;
  logic [20:0] exe_out_len = '0;
  logic [PIW-1:0] exe_rd_addr = '0;
  logic [63:0] exe_rd_data;
  logic        exe_wr = 1'b0;
  logic [PIW-1:0] exe_wr_addr = '0;
  logic [63:0] exe_wr_data = '0;

  always #2.5 clk = ~clk;

  mbx_doorbell_regs u_mbx_doorbell_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .bg_opcode(bg_opcode), .bg_pct(bg_pct), .bg_aborted(bg_aborted),
    .bg_rc(bg_rc), .exe_start(exe_start), .exe_set(exe_set), .exe_op(exe_op),
    .exe_len(exe_len), .exe_done(exe_done), .exe_rc(exe_rc),
    .exe_out_len(exe_out_len), .exe_rd_addr(exe_rd_addr),
    .exe_rd_data(exe_rd_data), .exe_wr(exe_wr), .exe_wr_addr(exe_wr_addr),
    .exe_wr_data(exe_wr_data)
  );

  int checks = 0, errors = 0;
  int n_start = 0, n_done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] snap_seen;
  logic [7:0]  seen_set, seen_op;
  logic [20:0] seen_len;

  task automatic chk(input bit good, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (host_rvalid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "unexpected read data", host_rdata, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(host_rdata === e, t, host_rdata, e);
        end
      end
    end
  end

  // executor model: reads snapshot word 0, writes its inverse to payload word 0
  initial begin
    forever begin
      @(negedge clk);
      if (exe_start) begin
        seen_set = exe_set; seen_op = exe_op; seen_len = exe_len;
        n_start++;
        exe_rd_addr = '0;
        repeat (20) @(negedge clk);
        snap_seen   = exe_rd_data;
        exe_wr      = 1'b1;
        exe_wr_addr = '0;
        exe_wr_data = ~exe_rd_data;
        exe_done    = 1'b1;
        exe_rc      = {seen_op, seen_set};
        exe_out_len = seen_len + 21'd1;
        @(negedge clk);
        exe_wr   = 1'b0;
        exe_done = 1'b0;
        n_done++;
      end
    end
  end

  task automatic hw(input logic [AW-1:0] a, input logic [1:0] s,
                    input logic [63:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_size = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [AW-1:0] a, input logic [1:0] s,
                    input logic [63:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    host_rd = 1'b1; host_addr = a; host_size = s;
    @(negedge clk);
    host_rd = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and capability constant
    hr(12'h000, 2'd2, 64'h1CB, "R1 cap word");
    hr(12'h001, 2'd0, 64'h01, "R1 cap byte 1");
    hr(12'h004, 2'd2, 64'd0, "R1 ctrl reset");
    hr(12'h008, 2'd3, 64'd0, "R1 cmd reset");
    hr(12'h010, 2'd3, 64'd0, "R1 sts reset");

    // R4 read-only words
    hw(12'h000, 2'd0, 64'hFF);
    hr(12'h000, 2'd2, 64'h1CB, "R4 cap write ignored");
    hw(12'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    hr(12'h010, 2'd3, 64'd0, "R4 sts write ignored");

    // R5 live busy flag, R6 background packing
    bg_opcode = 16'h1234; bg_pct = 7'd55; bg_rc = 16'hBEEF;
    hw(12'h018, 2'd3, 64'd0);
    hr(12'h018, 2'd3, 64'h0000_BEEF_0037_1234, "R6 bg word packed, R4 write ignored");
    hr(12'h01A, 2'd1, 64'h0037, "R6 bg pct halfword");
    hr(12'h010, 2'd0, 64'h1, "R5 busy when pct<100");
    bg_aborted = 1'b1;
    hr(12'h010, 2'd0, 64'h0, "R5 idle when aborted");
    bg_aborted = 1'b0; bg_pct = 7'd100;
    hr(12'h010, 2'd0, 64'h0, "R5 idle when pct=100");

    // R3 sub-word lanes
    hw(12'h009, 2'd0, 64'h5A);
    hr(12'h008, 2'd3, 64'h5A00, "R3 byte write lane");
    hr(12'h009, 2'd0, 64'h5A, "R3 byte read");
    hw(12'h00E, 2'd1, 64'hBEEF);
    hr(12'h00C, 2'd2, 64'hBEEF_0000, "R3 halfword lane");

    // R2 illegal accesses
    hw(12'h00A, 2'd2, 64'h1111_1111);
    hr(12'h008, 2'd3, 64'hBEEF_0000_0000_5A00, "R2 misaligned write dropped");
    hr(12'h009, 2'd1, 64'd0, "R2 misaligned read zero");
    hr(12'h000, 2'd3, 64'd0, "R2 8-byte at offset 0 read zero");
    s0 = n_start;
    hw(12'h000, 2'd3, 64'h1_0000_0000);
    repeat (300) @(negedge clk);
    chk(n_start == s0, "R2 8-byte write at offset 0 no start", 64'(n_start), 64'(s0));
    hr(12'h004, 2'd2, 64'd0, "R2 ctrl untouched");

    // R13 unmapped
    hr(12'h820, 2'd3, 64'd0, "R13 past payload end");
    hr(12'hFF8, 2'd3, 64'd0, "R13 top of window");

    // R7 payload
    hw(12'h020, 2'd3, 64'hA5A5_0102_0304_0506);
    hw(12'h028, 2'd2, 64'h1122_3344);
    hr(12'h020, 2'd3, 64'hA5A5_0102_0304_0506, "R7 payload word");
    hr(12'h02A, 2'd1, 64'h1122, "R7 payload halfword");

    // R8 R9 R10 R12 command round trip
    hw(12'h008, 2'd3, 64'h000C_2103);
    s0 = n_done;
    hw(12'h004, 2'd2, 64'h1);
    wait (n_start == 1);
    @(negedge clk);
    hw(12'h030, 2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
    hw(12'h008, 2'd3, 64'h0000_0077_7777);
    hw(12'h004, 2'd2, 64'h0);
    wait (n_done == s0 + 1);
    repeat (3) @(negedge clk);
    chk({seen_set, seen_op} == 16'h0321, "R9 latched set/op",
        64'({seen_set, seen_op}), 64'h0321);
    chk(seen_len == 21'd12, "R9 latched length", 64'(seen_len), 64'd12);
    chk(snap_seen == 64'hA5A5_0102_0304_0506, "R8 snapshot holds input",
        snap_seen, 64'hA5A5_0102_0304_0506);
    hr(12'h004, 2'd2, 64'd0, "R10 doorbell cleared");
    hr(12'h008, 2'd3, 64'h000D_2103, "R10 cmd rewritten with out length");
    hr(12'h010, 2'd3, 64'h0000_2103_0000_0000, "R10 sts rc");
    hr(12'h020, 2'd3, ~64'hA5A5_0102_0304_0506, "R10 executor output");
    hr(12'h028, 2'd3, 64'd0, "R8 payload wiped");
    hr(12'h030, 2'd3, 64'd0, "R12 payload write while busy dropped");

    // R11 length limit
    s0 = n_start;
    hw(12'h008, 2'd3, 64'h0801_4407);
    hw(12'h004, 2'd2, 64'h1);
    repeat (10) @(negedge clk);
    chk(n_start == s0, "R11 oversize no start", 64'(n_start), 64'(s0));
    hr(12'h008, 2'd3, 64'h0000_4407, "R11 cmd out length zero");
    hr(12'h010, 2'd3, 64'h0000_0005_0000_0000, "R11 internal error rc");
    hr(12'h004, 2'd2, 64'd0, "R11 doorbell cleared");

    s0 = n_done;
    hw(12'h008, 2'd3, 64'h0800_3001);
    hw(12'h004, 2'd2, 64'h1);
    wait (n_done == s0 + 1);
    repeat (3) @(negedge clk);
    chk(seen_len == 21'd2048, "R11 length at limit accepted",
        64'(seen_len), 64'd2048);
    hr(12'h008, 2'd3, 64'h0801_3001, "R10 cmd at limit");

    finish_run();
  end
endmodule